// File: doc/BRIEF.md
# Shadow-Guided Victim Selection Tag Cache

This block models the tag side of a set-associative cache whose replacement choice is steered by a second, smaller tag store. The second store, called the shadow here, remembers the line addresses most recently thrown out of the main cache. A line that is evicted, requested again and refilled will find its address in the shadow. It is treated as a line in repeated use. A line that has never been evicted is treated as probably transient, so it is the one chosen for eviction first.

Each cycle a client may present one line address. One cycle later the block reports whether the line was resident. In that same cycle it reports the full line address of any line it had to throw out to make room. No data is stored. The block is meant as a replacement-policy engine or as a miss-pattern model next to a real data array.

With the default sizes, the shadow has as many ways as the main cache, and two main sets share each shadow set. The most recent eviction into a shadow set is never resident in the main cache. So at least one way of a full set is always unprotected. Even so, the victim logic falls back to the plain least-recently-used way if every way is protected, and it refreshes a shadow entry instead of duplicating it if an address is evicted twice.

Top module: `evict_guard_cache`

## Requirements
- R1: While reset is held and in the first cycle after it, rsp_valid, rsp_hit and evict_valid are low. Reset empties every way, so the first lookup of any line misses.
- R2: A request with req_valid high produces rsp_valid high exactly one clock later. Any eviction it causes is reported in that same cycle. A cycle without a request gives rsp_valid and evict_valid low in the following cycle, and changes no state.
- R3: A line address hits when it is resident in the main set selected by its low 4 bits. The remaining upper bits form the tag. A hit makes that line the most recently used in its set.
- R4: A miss in a set that still has an empty way fills that way, reports evict_valid low and writes nothing into the shadow.
- R5: A miss in a full set replaces exactly one line. evict_addr carries that line's full 12-bit line address, which has the same low 4 bits as the request. If no resident line of the set is in the shadow, the least recently used line is the one replaced. A replaced line misses when it is next requested.
- R6: On a miss in a full set, the line replaced is the least recently used among the lines whose addresses are absent from the shadow. A protected line survives even when it is the least recently used line of the set.
- R7: Every replaced line address is written into the shadow set selected by its low 3 bits. A line that is later refilled is therefore protected under R6.
- R8: A shadow set holds only the four most recently replaced addresses mapping to it. The oldest is dropped on a fifth, and a dropped address no longer protects its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_addr | input | 12 | Line address of the lookup |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | The looked-up line was resident |
| evict_valid | output | 1 | A line was replaced by the previous lookup |
| evict_addr | output | 12 | Line address of the replaced line, zero when evict_valid is low |

## Verification
The embedded properties assume req_valid is never unknown once reset is released. They also assume req_addr is known in every cycle that req_valid is high, because the one-hot match check and the recency check look at state that the request writes. The bench holds reset for several cycles with req_valid low. It changes req_valid and req_addr only on falling clock edges and drives req_addr to zero whenever it idles, so every sampled request is stable and fully defined.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

   // Kind of state change a single lookup causes in the main store.
   typedef enum logic [1:0] {
      FILL_HIT   = 2'd0,
      FILL_FREE  = 2'd1,
      FILL_EVICT = 2'd2
   } fill_kind_e;

   // Constant helper for elaboration checks on sizes.
   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sgc_victim_pick.sv
// Chooses the oldest way among a candidate set; an empty candidate set
// falls back to the oldest way overall.
module sgc_victim_pick #(
   parameter  int WAYS  = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][WAY_W-1:0] ages,
   input  logic [WAYS-1:0]            cand,
   output logic [WAY_W-1:0]           pick_way
);

   logic [WAYS-1:0]  eff;
   logic [WAY_W-1:0] best_age;
   logic             seen;

   always_comb begin
      eff      = (|cand) ? cand : '1;
      pick_way = '0;
      best_age = '0;
      seen     = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (eff[w] && (!seen || ages[w] > best_age)) begin
            pick_way = WAY_W'(w);
            best_age = ages[w];
            seen     = 1'b1;
         end
      end
   end

endmodule

// File: rtl/sgc_tag_store.sv
// Set-associative tag array with per-way age counters (0 = newest).
// Used for both the main cache and the shadow of evicted addresses.
module sgc_tag_store #(
   parameter  int SETS  = 16,
   parameter  int WAYS  = 4,
   parameter  int TAG_W = 8,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   // lookup side (combinational)
   input  logic [IDX_W-1:0]           lk_idx,
   input  logic [TAG_W-1:0]           lk_tag,
   input  logic [WAYS-1:0]            keep_mask,
   output logic                       lk_hit,
   output logic [WAY_W-1:0]           lk_way,
   output logic [WAYS-1:0]            set_valid,
   output logic [WAYS-1:0][TAG_W-1:0] set_tags,
   output logic                       any_free,
   output logic [WAY_W-1:0]           repl_way,
   // update side (registered)
   input  logic                       upd_en,
   input  logic [IDX_W-1:0]           upd_idx,
   input  logic [WAY_W-1:0]           upd_way,
   input  logic [TAG_W-1:0]           upd_tag
);

   logic [WAYS-1:0]            vld_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
   logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];

   logic [WAYS-1:0][WAY_W-1:0] set_ages;
   logic [WAYS-1:0]            match;
   logic [WAY_W-1:0]           free_way;
   logic [WAY_W-1:0]           old_way;
   logic [WAY_W-1:0]           ref_age;

   assign set_valid = vld_q[lk_idx];
   assign set_tags  = tag_q[lk_idx];
   assign set_ages  = age_q[lk_idx];
   assign ref_age   = age_q[upd_idx][upd_way];

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = set_valid[w] && (set_tags[w] == lk_tag);
   end

   always_comb begin
      lk_way   = '0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w])      lk_way   = WAY_W'(w);
         if (!set_valid[w]) free_way = WAY_W'(w);
      end
   end

   assign lk_hit   = |match;
   assign any_free = ~&set_valid;

   sgc_victim_pick #(.WAYS(WAYS)) u_pick (
      .ages     (set_ages),
      .cand     (~keep_mask),
      .pick_way (old_way)
   );

   assign repl_way = any_free ? free_way : old_way;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               vld_q[s][w] <= 1'b0;
               tag_q[s][w] <= '0;
               age_q[s][w] <= WAY_W'(w);
            end
         end
      end else if (upd_en) begin
         vld_q[upd_idx][upd_way] <= 1'b1;
         tag_q[upd_idx][upd_way] <= upd_tag;
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == upd_way)
               age_q[upd_idx][w] <= '0;
            else if (age_q[upd_idx][w] < ref_age)
               age_q[upd_idx][w] <= age_q[upd_idx][w] + WAY_W'(1);
         end
      end
   end

   // R3: a line address may be resident in at most one way of its set
   a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R3: the way written by an access becomes the newest of its set
   a_r3_touch_is_newest: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> age_q[$past(upd_idx)][$past(upd_way)] == '0);

endmodule

// File: rtl/evict_guard_cache.sv
module evict_guard_cache
   import sgc_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int SETS    = 16,
   parameter int WAYS    = 4,
   parameter int SH_SETS = 8,
   parameter int SH_WAYS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              evict_valid,
   output logic [ADDR_W-1:0] evict_addr
);

   localparam int IDX_W    = $clog2(SETS);
   localparam int TAG_W    = ADDR_W - IDX_W;
   localparam int WAY_W    = $clog2(WAYS);
   localparam int SH_IDX_W = $clog2(SH_SETS);
   localparam int SH_TAG_W = ADDR_W - SH_IDX_W;
   localparam int SH_WAY_W = $clog2(SH_WAYS);

   // elaboration-time parameter checks
   if (!is_pow2(SETS) || !is_pow2(WAYS)) begin : g_bad_main
      $error("main store sets and ways must be powers of two above one");
   end
   if (!is_pow2(SH_SETS) || !is_pow2(SH_WAYS)) begin : g_bad_shadow
      $error("shadow sets and ways must be powers of two above one");
   end
   if (SH_IDX_W > IDX_W) begin : g_bad_alias
      $error("shadow index must be a subset of the main index");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the main set count");
   end

   logic [IDX_W-1:0]              lk_idx;
   logic [TAG_W-1:0]              lk_tag;
   logic [SH_IDX_W-1:0]           sh_idx;

   logic                          m_hit, m_free;
   logic [WAY_W-1:0]              m_way, m_repl;
   logic [WAYS-1:0]               m_valid;
   logic [WAYS-1:0][TAG_W-1:0]    m_tags;

   logic                          s_hit, s_free;
   logic [SH_WAY_W-1:0]           s_way, s_repl;
   logic [SH_WAYS-1:0]            s_valid;
   logic [SH_WAYS-1:0][SH_TAG_W-1:0] s_tags;

   logic [WAYS-1:0][ADDR_W-1:0]   way_addr;
   logic [WAYS-1:0]               prot;
   logic [ADDR_W-1:0]             vic_addr;
   fill_kind_e                    kind;
   logic                          log_evict;

   assign lk_idx = req_addr[IDX_W-1:0];
   assign lk_tag = req_addr[ADDR_W-1:IDX_W];
   assign sh_idx = req_addr[SH_IDX_W-1:0];

   for (genvar w = 0; w < WAYS; w++) begin : g_way_addr
      assign way_addr[w] = {m_tags[w], lk_idx};
   end

   // a resident line is protected when its address sits in the shadow set
   always_comb begin
      prot = '0;
      for (int w = 0; w < WAYS; w++) begin
         for (int s = 0; s < SH_WAYS; s++) begin
            if (m_valid[w] && s_valid[s] &&
                s_tags[s] == way_addr[w][ADDR_W-1:SH_IDX_W])
               prot[w] = 1'b1;
         end
      end
   end

   assign vic_addr = way_addr[m_repl];

   always_comb begin
      if (m_hit)       kind = FILL_HIT;
      else if (m_free) kind = FILL_FREE;
      else             kind = FILL_EVICT;
   end

   assign log_evict = req_valid && (kind == FILL_EVICT);

   sgc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_main (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (lk_idx),
      .lk_tag    (lk_tag),
      .keep_mask (prot),
      .lk_hit    (m_hit),
      .lk_way    (m_way),
      .set_valid (m_valid),
      .set_tags  (m_tags),
      .any_free  (m_free),
      .repl_way  (m_repl),
      .upd_en    (req_valid),
      .upd_idx   (lk_idx),
      .upd_way   (m_hit ? m_way : m_repl),
      .upd_tag   (lk_tag)
   );

   sgc_tag_store #(.SETS(SH_SETS), .WAYS(SH_WAYS), .TAG_W(SH_TAG_W)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (sh_idx),
      .lk_tag    (vic_addr[ADDR_W-1:SH_IDX_W]),
      .keep_mask ('0),
      .lk_hit    (s_hit),
      .lk_way    (s_way),
      .set_valid (s_valid),
      .set_tags  (s_tags),
      .any_free  (s_free),
      .repl_way  (s_repl),
      .upd_en    (log_evict),
      .upd_idx   (sh_idx),
      .upd_way   (s_hit ? s_way : s_repl),
      .upd_tag   (vic_addr[ADDR_W-1:SH_IDX_W])
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_hit     <= 1'b0;
         evict_valid <= 1'b0;
         evict_addr  <= '0;
      end else begin
         rsp_valid   <= req_valid;
         rsp_hit     <= req_valid && m_hit;
         evict_valid <= log_evict;
         evict_addr  <= log_evict ? vic_addr : '0;
      end
   end

   // R2: every request is answered on the next clock
   a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2: an idle cycle yields neither response nor eviction
   a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !evict_valid));

   // R5: an eviction is only ever reported with a miss response
   a_r5_evict_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> (rsp_valid && !rsp_hit));

   // R5: the replaced line belongs to the requested set
   a_r5_evict_same_set: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> evict_addr[IDX_W-1:0] == $past(req_addr[IDX_W-1:0]));

   // R4: a miss with an empty way never reports an eviction
   a_r4_free_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !m_hit && m_free) |=> !evict_valid);

   // R6: while an unprotected way exists, a protected way is never chosen
   a_r6_spare_protected: assert property (@(posedge clk) disable iff (!rst_n)
      (log_evict && !(&prot)) |-> !prot[m_repl]);

endmodule

// File: tb/evict_guard_cache_tb.sv
`timescale 1ns / 100ps
module evict_guard_cache_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [11:0] req_addr = '0;
   logic        rsp_valid, rsp_hit, evict_valid;
   logic [11:0] evict_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit          last_hit;
   bit          last_ev;
   logic [11:0] last_ea;

   // address-level reference: index 0 is the newest entry
   int mq [16][4];
   int mc [16];
   int sq [8][4];
   int sc [8];

   always #2.5 clk = ~clk;

   evict_guard_cache u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .rsp_valid   (rsp_valid),
      .rsp_hit     (rsp_hit),
      .evict_valid (evict_valid),
      .evict_addr  (evict_addr)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic bit in_shadow(input int x);
      int ss = x % 8;
      for (int i = 0; i < sc[ss]; i++)
         if (sq[ss][i] == x) return 1'b1;
      return 1'b0;
   endfunction

   task automatic shadow_log(input int x);
      int ss = x % 8;
      int p = -1;
      int n;
      for (int i = 0; i < sc[ss]; i++)
         if (sq[ss][i] == x) p = i;
      n = (p >= 0) ? p : ((sc[ss] < 4) ? sc[ss] : 3);
      for (int j = n; j > 0; j--) sq[ss][j] = sq[ss][j-1];
      sq[ss][0] = x;
      if (p < 0 && sc[ss] < 4) sc[ss]++;
   endtask

   task automatic model(input int a, output bit eh, output bit ee, output int ea);
      int s = a % 16;
      int pos = -1;
      int vp = -1;
      eh = 1'b0; ee = 1'b0; ea = 0;
      for (int i = 0; i < mc[s]; i++)
         if (mq[s][i] == a) pos = i;
      if (pos >= 0) begin
         eh = 1'b1;
         for (int j = pos; j > 0; j--) mq[s][j] = mq[s][j-1];
         mq[s][0] = a;
      end else if (mc[s] < 4) begin
         for (int j = mc[s]; j > 0; j--) mq[s][j] = mq[s][j-1];
         mq[s][0] = a;
         mc[s]++;
      end else begin
         for (int i = 0; i < 4; i++)
            if (!in_shadow(mq[s][i])) vp = i;
         if (vp < 0) vp = 3;
         ee = 1'b1;
         ea = mq[s][vp];
         for (int j = vp; j > 0; j--) mq[s][j] = mq[s][j-1];
         mq[s][0] = a;
         shadow_log(ea);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the response
   task automatic access(input logic [11:0] a, input string rq);
      bit eh, ee;
      int ea;
      model(int'(a), eh, ee, ea);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      last_hit = rsp_hit;
      last_ev  = evict_valid;
      last_ea  = evict_addr;
      chk(rsp_valid === 1'b1, "R2", "rsp_valid", int'(rsp_valid), 1);
      chk(rsp_hit === eh, rq, "rsp_hit", int'(rsp_hit), int'(eh));
      chk(evict_valid === ee, rq, "evict_valid", int'(evict_valid), int'(ee));
      if (ee) chk(evict_addr === 12'(ea), rq, "evict_addr", int'(evict_addr), ea);
   endtask

   task automatic idle_cycle();
      req_valid = 1'b0;
      req_addr  = '0;
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R2", "idle rsp_valid", int'(rsp_valid), 0);
      chk(evict_valid === 1'b0, "R2", "idle evict_valid", int'(evict_valid), 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(rsp_valid === 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
      chk(rsp_hit === 1'b0, "R1", "rsp_hit in reset", int'(rsp_hit), 0);
      chk(evict_valid === 1'b0, "R1", "evict_valid in reset", int'(evict_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
      chk(evict_valid === 1'b0, "R1", "evict_valid after reset", int'(evict_valid), 0);
   endtask

   // set 1: empty ways fill, hits refresh recency, plain oldest replaced
   task automatic t_cold_fill();
      for (int k = 0; k < 4; k++) begin
         access(12'h001 + 12'(k * 16), "R4");
         chk(!last_hit && !last_ev, "R1", "cold miss, no eviction",
             int'({last_hit, last_ev}), 0);
      end
      for (int k = 0; k < 4; k++) begin
         access(12'h001 + 12'(k * 16), "R3");
         chk(last_hit, "R3", "resident line hit", int'(last_hit), 1);
      end
      access(12'h001, "R3");
      access(12'h041, "R5");
      chk(last_ev && last_ea == 12'h011, "R5", "oldest line replaced",
          int'(last_ea), 'h011);
      access(12'h011, "R5");
      chk(!last_hit, "R5", "replaced line misses", int'(last_hit), 0);
   endtask

   // set 2: a refilled line is protected even when it is the oldest
   task automatic t_protect();
      for (int k = 0; k < 4; k++) access(12'h002 + 12'(k * 16), "R4");
      access(12'h042, "R5");
      chk(last_ea == 12'h002, "R5", "first replacement", int'(last_ea), 'h002);
      access(12'h002, "R7");
      chk(last_ea == 12'h012, "R7", "refill of evicted line", int'(last_ea), 'h012);
      access(12'h012, "R6");
      chk(last_ea == 12'h022, "R6", "unprotected oldest chosen", int'(last_ea), 'h022);
      access(12'h042, "R3");
      access(12'h032, "R3");
      access(12'h052, "R6");
      chk(last_ev && last_ea == 12'h042, "R6", "oldest protected line spared",
          int'(last_ea), 'h042);
      access(12'h002, "R6");
      chk(last_hit, "R6", "protected line still resident", int'(last_hit), 1);
   endtask

   // set 4: only four replaced addresses are remembered per shadow set
   task automatic t_shadow_depth();
      for (int k = 0; k < 9; k++) access(12'h004 + 12'(k * 16), "R8");
      access(12'h004, "R8");
      chk(last_ea == 12'h054, "R8", "reload after drop", int'(last_ea), 'h054);
      access(12'h084, "R3");
      access(12'h074, "R3");
      access(12'h064, "R3");
      access(12'h094, "R8");
      chk(last_ev && last_ea == 12'h004, "R8", "dropped address unprotected",
          int'(last_ea), 'h004);
   endtask

   task automatic t_idle();
      idle_cycle();
      idle_cycle();
      access(12'h094, "R2");
      chk(last_hit && !last_ev, "R2", "idle cycles left state alone",
          int'({last_hit, last_ev}), 2);
   endtask

   task automatic t_mixed();
      logic [15:0] lfsr = 16'hACE1;
      for (int n = 0; n < 700; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[15:13] == 3'd0) idle_cycle();
         else access({5'd0, 3'(lfsr[2:0] % 3'd6), lfsr[7:4]}, "R6");
      end
      idle_cycle();
   endtask

   initial begin
      for (int s = 0; s < 16; s++) mc[s] = 0;
      for (int s = 0; s < 8; s++) sc[s] = 0;
      t_reset();
      t_cold_fill();
      t_protect();
      t_shadow_depth();
      t_idle();
      t_mixed();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule